// File: doc/BRIEF.md
# Pseudo-SRAM Write Cycle Sequencer

This block turns host write requests into write cycles on an asynchronous pseudo-SRAM. Each request carries an address, a 16-bit data word and two byte enables. The block drives the memory pins: active-low chip select, write enable, lower and upper byte strobes, the address and the data bus with its output enable. Every timing interval is counted in cycles of the system clock. Each interval is a nanosecond parameter that is rounded up to whole cycles, using a clock-period parameter whose default is 5 ns.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The host must hold `req_valid` and its fields steady until that edge. While a write pulse is running, ready stays low. In the single decision cycle at the end of a write, ready may depend on `req_valid` and `req_addr`, and it rises only for a request that can be chained.

A write to the address already on the bus is chained with chip select still low, as long as the burst fits inside the 10 µs limit. Any other request, a lack of a request, or an exhausted budget closes the cycle: chip select goes high and is held there for the minimum high time before the next request is taken.

With the defaults:

| Quantity | Value |
|---|---|
| Write-enable pulse (PW) | 8 cycles |
| Recovery | 4 cycles |
| Write cycle length (WLEN) | 17 cycles |
| Chip-select high time (CP) | 2 cycles |
| Burst budget (MAXC) | 2000 cycles |

Top module: `psw_write_seq`

## Requirements
- R1: While reset is asserted, `mem_cs_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are high and `mem_dq_oe` is low. After reset is released, `req_ready` is high with chip select high.
- R2: A request accepted while chip select is high drives the pins on the next cycle: `mem_cs_n`=0 and `mem_we_n`=0 together, `mem_addr`/`mem_dq` carry the request, `mem_lb_n` = !be[0] (lower byte) and `mem_ub_n` = !be[1] (upper byte). Write enable is never low while chip select is high.
- R3: Each write-enable low pulse lasts PW cycles. PW is the largest of the rounded-up pulse-width, chip-select-to-end, address-to-end, strobe-to-end and data-setup minimums (8 by default).
- R4: Each write lasts WLEN cycles, from write enable falling to the next fall or to chip select rising. WLEN is the larger of the rounded-up cycle minimum and PW plus the recovery cycles (17 by default).
- R5: After an unchained write, chip select is high for at least CP cycles before it falls again. For a lone write, `req_ready` returns WLEN+CP+1 cycles after acceptance (20 by default).
- R6: A request to the current address that is waiting at the end of a write is accepted in that write's last cycle (WLEN-1 cycles of waiting). Chip select stays low and write enable falls again on the next cycle.
- R7: A request to a different address is held off until chip select has been high for CP cycles (WLEN+CP cycles of waiting after the previous acceptance).
- R8: Chip select never stays low for more than MAXC = floor(10000 ns / clock) cycles. A continuous same-address stream is split into bursts of floor(MAXC/WLEN) writes (117 by default).
- R9: `mem_dq_oe` rises with the write-enable fall and drops one cycle after write enable rises.
- R10: While chip select is low, the address does not change. Both byte strobes are high whenever write enable is high.
- R11: Every accepted request reaches the memory exactly once, in acceptance order. Ready stays low throughout a write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | ADDR_W | Write address |
| req_data | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | output | 16 | Memory data bus value |
| mem_dq_oe | output | 1 | Data bus output enable |

## Verification
The hardest state to reach is the burst budget running out. This needs more than a hundred back-to-back same-address requests, each presented in exactly the last cycle of the previous write. The bench therefore holds a same-address request continuously, so that every decision cycle finds it waiting. It then checks that the stream breaks into one burst of floor(MAXC/WLEN) writes followed by the remainder. Random traffic over a small address pool produces chained writes, address changes and idle gaps in mixed order.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_RECOV = 2'd2,
    ST_CSHI  = 2'd3
  } psw_state_e;

  // Round a nanosecond interval up to whole clock cycles.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    if (ns <= 0) return 0;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psw_counter.sv
module psw_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  // Saturating up-counter, restarted by clr.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (clr)          count <= '0;
    else if (count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/psw_budget.sv
module psw_budget #(
  parameter int W       = 12,
  parameter int WLEN    = 17,
  parameter int MAX_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_burst,
  output logic room
);
  // A further write fits if elapsed+1 cycles so far plus WLEN stay within MAX_CYC.
  localparam logic [W:0] LIMIT = (W+1)'(MAX_CYC - WLEN - 1);

  logic [W-1:0] elapsed;

  psw_counter #(.W(W)) u_elapsed (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (open_burst),
    .count (elapsed)
  );

  assign room = ({1'b0, elapsed} <= LIMIT);
endmodule

// File: rtl/psw_pins.sv
module psw_pins
  import psw_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [15:0]       ld_data,
  input  logic [1:0]        ld_be,
  input  psw_state_e        nxt_state,
  input  psw_state_e        cur_state,
  output logic              cs_n,
  output logic              we_n,
  output logic              lb_n,
  output logic              ub_n,
  output logic [ADDR_W-1:0] addr,
  output logic [15:0]       data,
  output logic              oe
);
  logic [1:0] be_q;
  logic [1:0] be_src;
  logic [1:0] strb_n;
  logic       pulse_nxt;

  assign be_src    = load ? ld_be : be_q;
  assign pulse_nxt = (nxt_state == ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= 1'b1;
      we_n <= 1'b1;
      oe   <= 1'b0;
      addr <= '0;
      data <= '0;
      be_q <= '0;
    end else begin
      if (load) begin
        addr <= ld_addr;
        data <= ld_data;
        be_q <= ld_be;
      end
      cs_n <= (nxt_state == ST_IDLE) || (nxt_state == ST_CSHI);
      we_n <= !pulse_nxt;
      oe   <= pulse_nxt || (cur_state == ST_WRITE);
    end
  end

  // One strobe register per byte lane.
  for (genvar b = 0; b < 2; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_n[b] <= 1'b1;
      else        strb_n[b] <= !(pulse_nxt && be_src[b]);
    end
  end

  assign lb_n = strb_n[0];
  assign ub_n = strb_n[1];

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);  // R2
  AST_OE_SPANS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe);  // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> $stable(addr));  // R10
  AST_STROBES_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    we_n |-> (lb_n && ub_n));  // R10
endmodule

// File: rtl/psw_write_seq.sv
module psw_write_seq
  import psw_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int CLK_NS    = 5,
  parameter int T_WC_NS   = 85,
  parameter int T_CW_NS   = 40,
  parameter int T_AW_NS   = 35,
  parameter int T_WP_NS   = 30,
  parameter int T_BW_NS   = 30,
  parameter int T_DW_NS   = 20,
  parameter int T_WR_NS   = 20,
  parameter int T_CP_NS   = 10,
  parameter int T_MAX_NS  = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  input  logic [1:0]        req_be,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dq,
  output logic              mem_dq_oe
);
  localparam int PW_CYC = imax(1, imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)),
                                       imax(imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_BW_NS, CLK_NS)),
                                            ns_to_cyc(T_DW_NS, CLK_NS))));
  localparam int WR_CYC  = imax(1, ns_to_cyc(T_WR_NS, CLK_NS));
  localparam int CP_CYC  = imax(1, ns_to_cyc(T_CP_NS, CLK_NS));
  localparam int WLEN    = imax(ns_to_cyc(T_WC_NS, CLK_NS), PW_CYC + WR_CYC);
  localparam int MAX_CYC = T_MAX_NS / CLK_NS;
  localparam int CW      = $clog2(MAX_CYC + 2);
  localparam int RW      = CW + 1;

  localparam logic [CW-1:0] PW_LAST   = CW'(PW_CYC - 1);
  localparam logic [CW-1:0] WR_LAST   = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] CP_LAST   = CW'(CP_CYC - 1);
  localparam logic [CW-1:0] WLEN_LAST = CW'(WLEN - 1);

  psw_state_e    state_q, state_d;
  logic [CW-1:0] ph_cnt, wc_cnt;
  logic          accept, ph_clr, rec_done, same_addr, room, open_burst;

  assign same_addr = (req_addr == mem_addr);
  assign rec_done  = (ph_cnt >= WR_LAST) && (wc_cnt >= WLEN_LAST);

  always_comb begin
    state_d   = state_q;
    req_ready = 1'b0;
    case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) state_d = ST_WRITE;
      end
      ST_WRITE: if (ph_cnt == PW_LAST) state_d = ST_RECOV;
      ST_RECOV: if (rec_done) begin
        req_ready = req_valid && same_addr && room;
        state_d   = req_ready ? ST_WRITE : ST_CSHI;
      end
      ST_CSHI:  if (ph_cnt == CP_LAST) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign accept     = req_valid && req_ready;
  assign ph_clr     = (state_d != state_q) || accept;
  assign open_burst = accept && (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  psw_counter #(.W(CW)) u_phase (
    .clk (clk), .rst_n (rst_n), .clr (ph_clr), .count (ph_cnt)
  );

  psw_counter #(.W(CW)) u_wcycle (
    .clk (clk), .rst_n (rst_n), .clr (accept), .count (wc_cnt)
  );

  psw_budget #(.W(CW), .WLEN(WLEN), .MAX_CYC(MAX_CYC)) u_budget (
    .clk (clk), .rst_n (rst_n), .open_burst (open_burst), .room (room)
  );

  psw_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .ld_addr   (req_addr),
    .ld_data   (req_data),
    .ld_be     (req_be),
    .nxt_state (state_d),
    .cur_state (state_q),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .lb_n      (mem_lb_n),
    .ub_n      (mem_ub_n),
    .addr      (mem_addr),
    .data      (mem_dq),
    .oe        (mem_dq_oe)
  );

  // Run-length monitors on the pins, used only by the checks below.
  localparam logic [RW-1:0] RTOP = '1;
  logic [RW-1:0] we_lo_run, cs_lo_run, cs_hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_run <= '0;
      cs_lo_run <= '0;
      cs_hi_run <= RW'(CP_CYC);
    end else begin
      we_lo_run <= mem_we_n ? '0 : ((we_lo_run == RTOP) ? we_lo_run : we_lo_run + 1'b1);
      cs_lo_run <= mem_cs_n ? '0 : ((cs_lo_run == RTOP) ? cs_lo_run : cs_lo_run + 1'b1);
      cs_hi_run <= !mem_cs_n ? '0 : ((cs_hi_run == RTOP) ? cs_hi_run : cs_hi_run + 1'b1);
    end
  end

  AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_run >= RW'(PW_CYC)));  // R3
  AST_CS_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (cs_hi_run >= RW'(CP_CYC)));  // R5
  AST_CS_LOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (cs_lo_run < RW'(MAX_CYC)));  // R8
  AST_HOLD_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE) |-> !req_ready);  // R11
endmodule

// File: tb/tb_psw_write_seq.sv
module tb_psw_write_seq;
  localparam int CLK_PERIOD = 5;
  localparam int AW  = 20;
  localparam int PKW = 2 + AW + 16;

  function automatic int cyc(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PW   = mx(mx(mx(cyc(30), cyc(40)), mx(cyc(35), cyc(30))), cyc(20));
  localparam int E_WR   = cyc(20);
  localparam int E_CP   = cyc(10);
  localparam int E_WLEN = mx(cyc(85), E_PW + E_WR);
  localparam int E_MAX  = 10000 / CLK_PERIOD;
  localparam int E_PERW = E_MAX / E_WLEN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0] req_be = '0;
  logic mem_cs_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_dq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [PKW-1:0] exp_q[$];
  int win_q[$];

  always #(CLK_PERIOD/2.0) clk = ~clk;

  psw_write_seq #(.ADDR_W(AW), .CLK_NS(CLK_PERIOD)) dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_data (req_data), .req_be (req_be),
    .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n),
    .mem_lb_n (mem_lb_n), .mem_ub_n (mem_ub_n),
    .mem_addr (mem_addr), .mem_dq (mem_dq), .mem_dq_oe (mem_dq_oe)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Pin monitor
  logic prev_we = 1, prev_cs = 1, oe_pend = 0, addr_moved = 0;
  logic [AW-1:0] prev_addr = '0;
  int we_low_len = 0, cs_low_len = 0, cs_high_len = 1000, since_fall = 0, win_writes = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_we = 1; prev_cs = 1; oe_pend = 0; we_low_len = 0; cs_low_len = 0;
      cs_high_len = 1000; since_fall = 0; win_writes = 0; addr_moved = 0;
    end else begin
      since_fall++;
      if (oe_pend) begin
        oe_pend = 0;
        if (mem_we_n) chk(mem_dq_oe == 0, "R9 oe drop", mem_dq_oe, 0);
      end
      if (prev_cs && !mem_cs_n) begin
        chk(cs_high_len >= E_CP, "R5 cs high time", cs_high_len, E_CP);
        addr_moved = 0;
      end
      if (!prev_cs && !mem_cs_n && mem_addr != prev_addr) addr_moved = 1;
      if (prev_we && !mem_we_n) begin
        chk(mem_cs_n == 0, "R2 cs low at we fall", mem_cs_n, 0);
        chk(mem_dq_oe == 1, "R9 oe with we", mem_dq_oe, 1);
        if (exp_q.size() == 0) chk(0, "R11 unexpected write", 0, 1);
        else begin
          logic [PKW-1:0] e;
          e = exp_q.pop_front();
          chk(mem_addr == e[16 +: AW], "R2 addr", mem_addr, e[16 +: AW]);
          chk(mem_dq == e[15:0], "R2 data", mem_dq, e[15:0]);
          chk(mem_lb_n == !e[PKW-2], "R2 lower strobe", mem_lb_n, !e[PKW-2]);
          chk(mem_ub_n == !e[PKW-1], "R2 upper strobe", mem_ub_n, !e[PKW-1]);
        end
        if (win_writes > 0) chk(since_fall == E_WLEN, "R6 chained spacing", since_fall, E_WLEN);
        win_writes++;
        since_fall = 0;
      end
      if (!prev_we && mem_we_n) begin
        chk(we_low_len == E_PW, "R3 we pulse", we_low_len, E_PW);
        chk(mem_dq_oe == 1, "R9 oe after we rise", mem_dq_oe, 1);
        oe_pend = 1;
      end
      if (mem_we_n && !mem_cs_n && (!mem_lb_n || !mem_ub_n))
        chk(0, "R10 strobe outside pulse", {mem_ub_n, mem_lb_n}, 3);
      if (!prev_cs && mem_cs_n) begin
        chk(since_fall == E_WLEN, "R4 write length", since_fall, E_WLEN);
        chk(cs_low_len <= E_MAX, "R8 cs low max", cs_low_len, E_MAX);
        chk(!addr_moved, "R10 address held", addr_moved, 0);
        win_q.push_back(win_writes);
        win_writes = 0;
      end
      we_low_len  = mem_we_n ? 0 : we_low_len + 1;
      cs_low_len  = mem_cs_n ? 0 : cs_low_len + 1;
      cs_high_len = mem_cs_n ? cs_high_len + 1 : 0;
      prev_we = mem_we_n; prev_cs = mem_cs_n; prev_addr = mem_addr;
    end
  end

  task automatic send(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be,
                      output int waits);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d; req_be = be;
    #1;
    waits = 0;
    while (!req_ready) begin
      @(negedge clk); #1; waits++;
    end
    exp_q.push_back({be, a, d});
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int w, lat;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_we_n && mem_lb_n && mem_ub_n, "R1 strobes high in reset",
        {mem_cs_n, mem_we_n, mem_lb_n, mem_ub_n}, 15);
    chk(mem_dq_oe == 0, "R1 oe low in reset", mem_dq_oe, 0);
    rst_n = 1;
    #1;
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);

    // R2/R5 lone write and ready latency
    send(20'h00010, 16'hA5C3, 2'b11, w);
    chk(w == 0, "R2 immediate accept", w, 0);
    @(negedge clk); req_valid = 0;
    lat = 1;
    #1;
    while (!req_ready && lat < 100) begin @(negedge clk); #1; lat++; end
    chk(lat == E_WLEN + E_CP + 1, "R5 ready latency", lat, E_WLEN + E_CP + 1);
    idle(5);

    // R6 chaining at the same address
    win_q.delete();
    send(20'h00200, 16'h1111, 2'b11, w);
    send(20'h00200, 16'h2222, 2'b01, w);
    chk(w == E_WLEN - 1, "R6 chain wait", w, E_WLEN - 1);
    send(20'h00200, 16'h3333, 2'b10, w);
    chk(w == E_WLEN - 1, "R6 chain wait 2", w, E_WLEN - 1);
    idle(40);
    chk(win_q.size() == 1 && win_q[0] == 3, "R6 one burst of three", win_q.size() > 0 ? win_q[0] : -1, 3);

    // R7 different address held off
    win_q.delete();
    send(20'h00300, 16'h4444, 2'b11, w);
    send(20'h00301, 16'h5555, 2'b00, w);
    chk(w == E_WLEN + E_CP, "R7 address change wait", w, E_WLEN + E_CP);
    idle(40);
    chk(win_q.size() == 2, "R7 two windows", win_q.size(), 2);

    // R8 budget split
    win_q.delete();
    for (int i = 0; i < E_PERW + 13; i++) send(20'h00777, 16'(i), 2'b11, w);
    idle(60);
    chk(win_q.size() == 2, "R8 window count", win_q.size(), 2);
    if (win_q.size() == 2) begin
      chk(win_q[0] == E_PERW, "R8 full burst", win_q[0], E_PERW);
      chk(win_q[1] == 13, "R8 remainder", win_q[1], 13);
    end

    // Random traffic
    for (int i = 0; i < 300; i++) begin
      int gap;
      send(20'h01000 + 20'($urandom % 3), 16'($urandom), 2'($urandom), w);
      gap = $urandom % 4;
      if (gap != 0) idle(gap * 7);
    end
    idle(60);
    chk(exp_q.size() == 0, "R11 all requests written", exp_q.size(), 0);
    summary();
  end
endmodule